// File: doc/BRIEF.md
# MDIO Clause-22 Command Gateway

This block is a management-bus master for Ethernet PHYs. It has two 32-bit registers. Software starts a transaction by writing one command word to the gateway register with its busy bit set. The block then clocks a complete clause-22 management frame onto the MDC and MDIO pins. Software polls the same register until busy drops. For a read, it then finds the PHY's 16-bit reply in the low half of that word. The second register sets the MDC rate and two positions inside each MDC period: the core clock on which a new output bit is launched, and the core clock on which the MDIO input is sampled.

Every frame is 64 MDC periods long, one bit per period:
- 32 bits of preamble, all ones.
- The start field 01.
- The 2-bit opcode.
- The 5-bit PHY address and the 5-bit register address, most significant bit first.
- Two turnaround bits.
- 16 data bits.

The MDIO pin is modelled as an output value plus an output enable, so the pad can work as open drain or tri-state. A command written while a frame is in flight is dropped. Writing an all-zero word abandons the frame in flight at once.

Top module: `mdio_gateway`

## Requirements
- R1: After reset the gateway register reads 0 and the configuration register reads 0x0D061800: change point 13, sample point 6, period value 24. MDC is low and the MDIO output enable is low.
- R2: A gateway write made while not busy is stored. If the word has bit 30 (busy) set, bit 28 (start select) set and opcode bits 27:26 equal to 01 (write) or 10 (read), a frame starts and bit 30 reads back as 1 until the frame completes.
- R3: Each frame carries 64 bits, one per MDC period, and each bit is valid at the rising edge of MDC. The order is:
  - 32 ones;
  - start bits 0 then 1;
  - the opcode;
  - the PHY address from bits 25:21, MSB first;
  - the register address from bits 20:16, MSB first;
  - two turnaround bits;
  - 16 data bits.
- R4: In a write frame, MDIO is driven for all 64 bits. The turnaround is 1 then 0, and the data is bits 15:0 of the word, MSB first.
- R5: In a read frame, MDIO is driven for the first 46 bits and released for the turnaround and the 16 data bits. At completion, bits 15:0 of the gateway word hold the captured data, MSB first, and the other fields are unchanged.
- R6: The configuration register reads back what was last written. With the period value N in bits 15:8, one MDC period lasts 2*(N+1) core clocks: low for the first N+1 and high for the rest.
- R7: The output change point P in bits 31:24 sets when each bit is launched, P core clocks into its MDC period. The first output enable is seen P+1 clock edges after the edge that accepts the command.
- R8: The input sample point in bits 23:16 sets where the read input is captured inside each data bit's own MDC period. The input passes through a synchronizer first.
- R9: A non-zero gateway write while busy is ignored: the stored command fields and the frame in flight do not change.
- R10: An all-zero gateway write while busy ends the frame on the next edge. Busy clears, the word reads 0, MDC goes low and MDIO is released.
- R11: A gateway write with bit 28 clear, with opcode 00 or 11, or with bit 30 clear starts no frame. It is stored with bit 30 read back as 0.
- R12: While not busy, MDC stays low and the MDIO output enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 1 | Write target: 0 gateway, 1 configuration |
| wr_data | input | 32 | Register write data |
| rd_sel | input | 1 | Read target: 0 gateway, 1 configuration |
| rd_data | output | 32 | Combinational register read data |
| mdio_i | input | 1 | MDIO pin input |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable, high when the block drives the pin |

## Verification
The assertions assume that a write strobe lasts one cycle. They also assume that software changes the configuration register only while the block is idle. The sample and change points must both lie inside the low half of the MDC period, so that a launched bit is settled before the rising edge and the read input is taken before the PHY changes it again. The stimulus writes the configuration only between frames and uses point pairs (2, 6) with N = 9 and (1, 3) with N = 4. The modelled PHY changes its read data only just after an MDC rising edge. Every gateway write is a single-cycle strobe applied away from the clock edge.

// File: rtl/mdio_gw_pkg.sv
package mdio_gw_pkg;

   // gateway word field positions (decoded by software, so they are fixed)
   localparam int GW_W         = 32;
   localparam int F_REG_LSB    = 16;
   localparam int F_PHY_LSB    = 21;
   localparam int F_OP_LSB     = 26;
   localparam int F_ST_BIT     = 28;
   localparam int F_BUSY_BIT   = 30;

   // configuration word field positions
   localparam int C_DIV_LSB    = 8;
   localparam int C_SAMP_LSB   = 16;
   localparam int C_LAUNCH_LSB = 24;
   localparam int C_FIELD_W    = 8;

   // frame tail after the preamble: start(2) op(2) phy(5) reg(5) ta(2) data(16)
   localparam int TAIL_W       = 32;

   typedef enum logic [1:0] {
      OP_NONE  = 2'b00,
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10,
      OP_RSVD  = 2'b11
   } mdio_op_e;

   typedef struct packed {
      mdio_op_e    op;
      logic [4:0]  phy_a;
      logic [4:0]  reg_a;
      logic [15:0] data;
   } mdio_cmd_t;

   function automatic mdio_cmd_t word_to_cmd(input logic [GW_W-1:0] w);
      mdio_cmd_t c;
      c.op    = mdio_op_e'(w[F_OP_LSB +: 2]);
      c.phy_a = w[F_PHY_LSB +: 5];
      c.reg_a = w[F_REG_LSB +: 5];
      c.data  = w[15:0];
      return c;
   endfunction

   function automatic logic cmd_launchable(input logic [GW_W-1:0] w);
      return w[F_BUSY_BIT] && w[F_ST_BIT] &&
             ((w[F_OP_LSB +: 2] == OP_WRITE) || (w[F_OP_LSB +: 2] == OP_READ));
   endfunction

   function automatic logic [TAIL_W-1:0] frame_tail(input mdio_cmd_t c);
      logic [1:0] ta;
      ta = (c.op == OP_READ) ? 2'b00 : 2'b10;
      return {2'b01, c.op, c.phy_a, c.reg_a, ta, c.data};
   endfunction

endpackage

// File: rtl/mdio_gw_mdc_gen.sv
module mdio_gw_mdc_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half_div,
   input  logic [DIV_W-1:0] samp_pt,
   input  logic [DIV_W-1:0] launch_pt,
   output logic             mdc,
   output logic             launch,
   output logic             sample,
   output logic             period_end
);
   localparam int CNT_W = DIV_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_cnt;
   logic [CNT_W-1:0] half_cnt;
   logic [CNT_W-1:0] samp_cnt;
   logic [CNT_W-1:0] launch_cnt;

   // period = 2*(half_div+1) clocks, so the last count is 2*half_div+1
   assign last_cnt   = {half_div, 1'b1};
   assign half_cnt   = {1'b0, half_div};
   assign samp_cnt   = {1'b0, samp_pt};
   assign launch_cnt = {1'b0, launch_pt};

   assign period_end = run && (cnt_q == last_cnt);
   assign launch     = run && (cnt_q == launch_cnt);
   assign sample     = run && (cnt_q == samp_cnt);
   assign mdc        = run && (cnt_q > half_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || period_end)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/mdio_gw_sync.sv
module mdio_gw_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= '1;
            end else begin
               sh_q[0] <= d;
               for (int i = 1; i < STAGES; i++)
                  sh_q[i] <= sh_q[i-1];
            end
         end
         assign q = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/mdio_gw_seq.sv
module mdio_gw_seq
   import mdio_gw_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        abort,
   input  mdio_cmd_t   cmd_i,
   input  logic        launch,
   input  logic        sample,
   input  logic        period_end,
   input  logic        din,
   output logic        active,
   output logic        done,
   output logic        dout,
   output logic        dout_en,
   output logic [15:0] rx_data
);
   localparam int FRAME_LEN = PRE_LEN + TAIL_W;
   localparam int IDX_W     = $clog2(FRAME_LEN);
   localparam logic [IDX_W-1:0] PRE_I  = IDX_W'(PRE_LEN);
   localparam logic [IDX_W-1:0] TA_I   = IDX_W'(PRE_LEN + 14);
   localparam logic [IDX_W-1:0] DATA_I = IDX_W'(PRE_LEN + 16);
   localparam logic [IDX_W-1:0] LAST_I = IDX_W'(FRAME_LEN - 1);

   logic [IDX_W-1:0]  idx_q;
   logic [TAIL_W-1:0] tail_q;
   logic              rd_q;
   logic              active_q;
   logic              dout_q;
   logic              oe_q;
   logic [15:0]       rx_q;
   logic [IDX_W-1:0]  back_idx;
   logic              tail_bit;
   logic              at_last;

   assign back_idx = LAST_I - idx_q;
   assign tail_bit = tail_q[back_idx[4:0]];
   assign at_last  = (idx_q == LAST_I);
   assign done     = active_q && period_end && at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q    <= '0;
         tail_q   <= '0;
         rd_q     <= 1'b0;
         active_q <= 1'b0;
         dout_q   <= 1'b0;
         oe_q     <= 1'b0;
         rx_q     <= '0;
      end else if (start) begin
         idx_q    <= '0;
         tail_q   <= frame_tail(cmd_i);
         rd_q     <= (cmd_i.op == OP_READ);
         active_q <= 1'b1;
         oe_q     <= 1'b0;
         rx_q     <= '0;
      end else if (abort) begin
         active_q <= 1'b0;
         oe_q     <= 1'b0;
         dout_q   <= 1'b0;
      end else if (active_q) begin
         if (launch) begin
            dout_q <= (idx_q < PRE_I) ? 1'b1 : tail_bit;
            oe_q   <= !(rd_q && (idx_q >= TA_I));
         end
         if (sample && rd_q && (idx_q >= DATA_I))
            rx_q <= {rx_q[14:0], din};
         if (period_end) begin
            if (at_last) begin
               active_q <= 1'b0;
               oe_q     <= 1'b0;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   assign active  = active_q;
   assign dout    = dout_q;
   assign dout_en = oe_q;
   assign rx_data = rx_q;

endmodule

// File: rtl/mdio_gateway.sv
module mdio_gateway
   import mdio_gw_pkg::*;
#(
   parameter int PRE_LEN     = 32,
   parameter int SYNC_STAGES = 2,
   parameter int RST_DIV     = 24,
   parameter int RST_SAMP    = 6,
   parameter int RST_LAUNCH  = 13
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        wr_sel,
   input  logic [31:0] wr_data,
   input  logic        rd_sel,
   output logic [31:0] rd_data,
   input  logic        mdio_i,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe
);
   localparam int PERIOD_LAST = 2 * RST_DIV + 1;
   localparam logic [GW_W-1:0] CFG_RST =
      {C_FIELD_W'(RST_LAUNCH), C_FIELD_W'(RST_SAMP), C_FIELD_W'(RST_DIV), 8'h00};

   generate
      if (PRE_LEN < 1 || PRE_LEN > 64) begin : g_bad_pre
         $error("mdio_gateway: PRE_LEN must lie in 1..64");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("mdio_gateway: SYNC_STAGES must lie in 0..4");
      end
      if (RST_DIV < 0 || RST_DIV > 255) begin : g_bad_div
         $error("mdio_gateway: RST_DIV must fit the 8-bit field");
      end
      if (RST_SAMP > PERIOD_LAST || RST_LAUNCH > PERIOD_LAST) begin : g_bad_pts
         $error("mdio_gateway: reset sample/launch points exceed the MDC period");
      end
   endgenerate

   logic [GW_W-1:0] gw_q;
   logic [GW_W-1:0] cfg_q;
   logic            busy;
   logic            gw_hit;
   logic            cfg_hit;
   logic            start;
   logic            abort;
   logic            seq_active;
   logic            seq_done;
   logic [15:0]     seq_rx;
   logic            din_sync;
   logic            tick_launch;
   logic            tick_sample;
   logic            tick_end;
   mdio_cmd_t       new_cmd;

   assign busy    = gw_q[F_BUSY_BIT];
   assign gw_hit  = wr_en && !wr_sel;
   assign cfg_hit = wr_en && wr_sel;
   assign start   = gw_hit && !busy && cmd_launchable(wr_data);
   assign abort   = gw_hit && busy && (wr_data == '0);
   assign new_cmd = word_to_cmd(wr_data);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gw_q  <= '0;
         cfg_q <= CFG_RST;
      end else begin
         if (cfg_hit)
            cfg_q <= wr_data;
         if (gw_hit && !busy) begin
            gw_q             <= wr_data;
            gw_q[F_BUSY_BIT] <= cmd_launchable(wr_data);
         end else if (abort) begin
            gw_q <= '0;
         end else if (seq_done) begin
            gw_q[F_BUSY_BIT] <= 1'b0;
            if (gw_q[F_OP_LSB +: 2] == OP_READ)
               gw_q[15:0] <= seq_rx;
         end
      end
   end

   assign rd_data = rd_sel ? cfg_q : gw_q;

   mdio_gw_mdc_gen #(
      .DIV_W (C_FIELD_W)
   ) u_mdc_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (seq_active),
      .half_div   (cfg_q[C_DIV_LSB +: C_FIELD_W]),
      .samp_pt    (cfg_q[C_SAMP_LSB +: C_FIELD_W]),
      .launch_pt  (cfg_q[C_LAUNCH_LSB +: C_FIELD_W]),
      .mdc        (mdc),
      .launch     (tick_launch),
      .sample     (tick_sample),
      .period_end (tick_end)
   );

   mdio_gw_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (mdio_i),
      .q     (din_sync)
   );

   mdio_gw_seq #(
      .PRE_LEN (PRE_LEN)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .abort      (abort),
      .cmd_i      (new_cmd),
      .launch     (tick_launch),
      .sample     (tick_sample),
      .period_end (tick_end),
      .din        (din_sync),
      .active     (seq_active),
      .done       (seq_done),
      .dout       (mdio_o),
      .dout_en    (mdio_oe),
      .rx_data    (seq_rx)
   );

endmodule

// File: rtl/mdio_gateway_chk.sv
module mdio_gateway_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic        wr_sel,
   input logic [31:0] wr_data,
   input logic        mdc,
   input logic        mdio_oe,
   input logic [31:0] gw_word
);
   logic busy;
   logic launchable;
   assign busy       = gw_word[30];
   assign launchable = wr_data[30] && wr_data[28] &&
                       ((wr_data[27:26] == 2'b01) || (wr_data[27:26] == 2'b10));

   // R12: the bus is quiet whenever no frame is pending
   assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe));

   // R2: busy only appears as the result of a gateway write
   assert_busy_from_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wr_en && !wr_sel));

   // R9: a non-zero command written while busy leaves the stored fields alone
   assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel && busy && (wr_data != 32'h0)) |=> (gw_word[29:16] == $past(gw_word[29:16])));

   // R10: an all-zero write while busy ends the frame on the next edge
   assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel && busy && (wr_data == 32'h0)) |=> (!busy && !mdio_oe && !mdc));

   // R11: a command that is not a valid clause-22 launch does not set busy
   assert_reject_invalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel && !busy && !launchable) |=> !busy);

endmodule

bind mdio_gateway mdio_gateway_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_sel  (wr_sel),
   .wr_data (wr_data),
   .mdc     (mdc),
   .mdio_oe (mdio_oe),
   .gw_word (gw_q)
);

// File: tb/mdio_gateway_bench.sv
module mdio_gateway_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_sel = 1'b0;
   logic [31:0] rd_data;
   logic        mdio_i = 1'b1;
   logic        mdc;
   logic        mdio_o;
   logic        mdio_oe;

   always #4 clk = ~clk;

   mdio_gateway u_mdio_gateway (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .rd_sel  (rd_sel),
      .rd_data (rd_data),
      .mdio_i  (mdio_i),
      .mdc     (mdc),
      .mdio_o  (mdio_o),
      .mdio_oe (mdio_oe)
   );

   typedef struct {
      logic [63:0] bits;
      logic [63:0] drive;
   } frame_t;

   frame_t      exp_q[$];
   logic [15:0] phy_reply = '0;

   // main-process counters
   int checks = 0;
   int fails  = 0;
   int pushed = 0;
   // monitor-process counters
   int mon_checks = 0;
   int mon_fails  = 0;
   int frames_seen = 0;
   int total_rises = 0;
   int last_period = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: sample the pins at every MDC rising edge, model the PHY, compare frames
   initial begin : monitor
      logic        mdc_prev;
      int          rise_cnt;
      int          since;
      logic [63:0] got_bits;
      logic [63:0] got_oe;
      frame_t      e;
      mdc_prev = 1'b0;
      rise_cnt = 0;
      since    = 0;
      got_bits = '0;
      got_oe   = '0;
      forever begin
         @(negedge clk);
         since++;
         if (wr_en && !wr_sel && wr_data == 32'h0)
            rise_cnt = 0;
         if (mdc && !mdc_prev) begin
            total_rises++;
            last_period = since;
            since = 0;
            got_bits[63-rise_cnt] = mdio_o;
            got_oe[63-rise_cnt]   = mdio_oe;
            if (rise_cnt + 1 >= 48 && rise_cnt + 1 <= 63)
               mdio_i = phy_reply[63-(rise_cnt+1)];
            else
               mdio_i = 1'b1;
            rise_cnt++;
            if (rise_cnt == 64) begin
               rise_cnt = 0;
               frames_seen++;
               mon_checks += 2;
               if (exp_q.size() == 0) begin
                  mon_fails += 2;
                  $display("FAIL R3 unexpected frame actual=%h expected=none", got_bits);
               end else begin
                  e = exp_q.pop_front();
                  if (got_oe !== e.drive) begin
                     mon_fails++;
                     $display("FAIL R4/R5 drive pattern actual=%h expected=%h", got_oe, e.drive);
                  end
                  if ((got_bits & e.drive) !== (e.bits & e.drive)) begin
                     mon_fails++;
                     $display("FAIL R3 frame bits actual=%h expected=%h",
                              got_bits & e.drive, e.bits & e.drive);
                  end
               end
            end
         end
         mdc_prev = mdc;
      end
   end

   task automatic gw_write(input logic sel, input logic [31:0] w);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_sel  = sel;
      wr_data = w;
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = '0;
   endtask

   function automatic logic [31:0] mk_word(input logic busy, input logic st, input logic [1:0] op,
                                           input logic [4:0] phy, input logic [4:0] rg,
                                           input logic [15:0] dat);
      return {1'b0, busy, 1'b0, st, op, phy, rg, dat};
   endfunction

   // driver: write a launchable command, push the expected frame, return launch delay
   task automatic issue(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] dat, input logic [15:0] rep, input bit push,
                        output int delay);
      frame_t      f;
      logic [31:0] w;
      w = mk_word(1'b1, 1'b1, op, phy, rg, dat);
      f.bits  = {32'hFFFF_FFFF, 2'b01, op, phy, rg, (op == 2'b10) ? 2'b00 : 2'b10, dat};
      f.drive = (op == 2'b10) ? 64'hFFFF_FFFF_FFFC_0000 : 64'hFFFF_FFFF_FFFF_FFFF;
      phy_reply = rep;
      if (push) begin
         exp_q.push_back(f);
         pushed++;
      end
      gw_write(1'b0, w);
      delay = 0;
      while (!mdio_oe && delay < 600) begin
         @(negedge clk);
         delay++;
      end
   endtask

   task automatic wait_idle();
      int n;
      n = 0;
      rd_sel = 1'b0;
      @(negedge clk);
      while (rd_data[30] && n < 5000) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures",
               checks + mon_checks + 1, fails + mon_fails + 1);
      $finish;
   end

   initial begin : main
      int          d;
      int          r0;
      logic [31:0] w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_sel = 1'b0; #1;
      chk(rd_data == 32'h0, "R1 gateway reset", 64'(rd_data), 64'h0);
      rd_sel = 1'b1; #1;
      chk(rd_data == 32'h0D06_1800, "R1 config reset", 64'(rd_data), 64'h0D061800);
      chk(!mdc && !mdio_oe, "R1 pins reset", {62'h0, mdc, mdio_oe}, 64'h0);

      // R6 config write and readback: N=9, sample 6, launch 2
      gw_write(1'b1, 32'h0206_0900);
      rd_sel = 1'b1; #1;
      chk(rd_data == 32'h0206_0900, "R6 config readback", 64'(rd_data), 64'h02060900);

      // R2/R3/R4/R7 write frame
      w = mk_word(1'b1, 1'b1, 2'b01, 5'h13, 5'h0A, 16'hA5C3);
      issue(2'b01, 5'h13, 5'h0A, 16'hA5C3, 16'h0000, 1'b1, d);
      chk(d == 3, "R7 launch delay", 64'(d), 64'd3);
      rd_sel = 1'b0; #1;
      chk(rd_data == w, "R2 busy while running", 64'(rd_data), 64'(w));
      wait_idle();
      chk(rd_data == (w & ~32'h4000_0000), "R4 word after write", 64'(rd_data), 64'(w & ~32'h4000_0000));
      chk(last_period == 20, "R6 MDC period N=9", 64'(last_period), 64'd20);

      // R5/R8 read frame
      w = mk_word(1'b1, 1'b1, 2'b10, 5'h01, 5'h02, 16'h1111);
      issue(2'b10, 5'h01, 5'h02, 16'h1111, 16'h3C5A, 1'b1, d);
      wait_idle();
      chk(rd_data == {w[31:31], 1'b0, w[29:16], 16'h3C5A}, "R5 R8 read data returned",
          64'(rd_data), 64'({w[31:31], 1'b0, w[29:16], 16'h3C5A}));

      // R9 write while busy is ignored
      w = mk_word(1'b1, 1'b1, 2'b01, 5'h05, 5'h1F, 16'h0F0F);
      issue(2'b01, 5'h05, 5'h1F, 16'h0F0F, 16'h0000, 1'b1, d);
      repeat (100) @(negedge clk);
      gw_write(1'b0, 32'h7FFF_FFFF);
      rd_sel = 1'b0; #1;
      chk(rd_data == w, "R9 word unchanged while busy", 64'(rd_data), 64'(w));
      wait_idle();
      chk(rd_data == (w & ~32'h4000_0000), "R9 word after frame", 64'(rd_data), 64'(w & ~32'h4000_0000));

      // R10 abort mid-frame (no frame expected)
      issue(2'b10, 5'h07, 5'h03, 16'h0000, 16'hFFFF, 1'b0, d);
      repeat (200) @(negedge clk);
      gw_write(1'b0, 32'h0);
      rd_sel = 1'b0; #1;
      chk(rd_data == 32'h0 && !mdio_oe && !mdc, "R10 abort",
          {rd_data, 30'h0, mdc, mdio_oe}, 64'h0);
      r0 = total_rises;
      repeat (60) @(negedge clk);
      chk(total_rises == r0 && !mdc && !mdio_oe, "R12 idle after abort",
          64'(total_rises - r0), 64'd0);

      // R11 invalid commands: opcode 00, then start select clear
      w = mk_word(1'b1, 1'b1, 2'b00, 5'h03, 5'h04, 16'h1234);
      gw_write(1'b0, w);
      rd_sel = 1'b0; #1;
      chk(rd_data == (w & ~32'h4000_0000), "R11 opcode 00 stored idle", 64'(rd_data), 64'(w & ~32'h4000_0000));
      w = mk_word(1'b1, 1'b0, 2'b01, 5'h03, 5'h04, 16'h1234);
      gw_write(1'b0, w);
      rd_sel = 1'b0; #1;
      chk(rd_data == (w & ~32'h4000_0000), "R11 start select clear stored idle", 64'(rd_data), 64'(w & ~32'h4000_0000));
      r0 = total_rises;
      repeat (100) @(negedge clk);
      chk(total_rises == r0 && !mdio_oe, "R11 R12 no frame", 64'(total_rises - r0), 64'd0);

      // second configuration: N=4, sample 3, launch 1
      gw_write(1'b1, 32'h0103_0400);
      w = mk_word(1'b1, 1'b1, 2'b10, 5'h1E, 5'h11, 16'h0000);
      issue(2'b10, 5'h1E, 5'h11, 16'h0000, 16'hF00D, 1'b1, d);
      chk(d == 2, "R7 launch delay point 1", 64'(d), 64'd2);
      wait_idle();
      chk(last_period == 10, "R6 MDC period N=4", 64'(last_period), 64'd10);
      chk(rd_data == {w[31:31], 1'b0, w[29:16], 16'hF00D}, "R8 read with sample point 3",
          64'(rd_data), 64'({w[31:31], 1'b0, w[29:16], 16'hF00D}));

      repeat (10) @(negedge clk);
      chk(frames_seen == pushed && exp_q.size() == 0, "R3 all frames observed",
          64'(frames_seen), 64'(pushed));

      $display("End of test - %0d assertions evaluated, %0d failures",
               checks + mon_checks, fails + mon_fails);
      $finish;
   end

endmodule